// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block turns a 32-bit virtual address into a 36-bit physical address by reading translation descriptors from memory, one at a time. A walk starts when the caller raises `req` while the walker is idle. The walker first reads the descriptor of the current process from a context table: `ctx_id` selects the entry and `ctx_base` gives where the table sits. It then descends through up to three table levels. The virtual page number splits into an 8-bit first-level index (va[31:24]), a 6-bit second-level index (va[23:18]) and a 6-bit third-level index (va[17:12]), above a 12-bit page offset.

Every descriptor is 32 bits wide, and its low two bits give the entry type. Type 1 points at the next table, and bits [31:2] shifted left by six give that table's byte address. Type 2 is a final entry. Its bits [31:8] hold the 24-bit physical page number, bits [7:5] an access code, bit 4 cacheable, bit 3 modified and bit 2 referenced. Type 0 (absent) and type 3 (reserved) end the walk with a fault. A final entry found early maps a larger region: the page-number bits that were not yet consumed as table indexes pass straight through from the virtual address.

Each walk ends with a single-cycle `done`. The result fields (`pa`, attributes, `fault`, `fault_kind` and `walk_level`) keep their values until the next walk finishes. Reset deassertion is synchronised inside the block.

Top module: `ptw_walker`

## Requirements
- R1: The first memory read of a walk goes to `ctx_base + 4*ctx_id`. This is level 0.
- R2: After a type-1 descriptor at level L (L < 3), the next read address is `{desc[31:2], 6'b0}` plus 4 times the level L+1 index. That index is va[31:24] for level 1, va[23:18] for level 2 and va[17:12] for level 3.
- R3: A type-2 descriptor at level 3 ends the walk with fault=0, fault_kind=0, pa = {desc[31:8], va[11:0]}, attr_acc=desc[7:5], attr_c=desc[4], attr_m=desc[3], attr_r=desc[2], and walk_level=3.
- R4: A type-2 descriptor at level 0, 1 or 2 ends the walk early, reporting walk_level as that level and the same attribute fields as R3. The result is pa = {desc[31:28], va[31:0]} at level 0, {desc[31:20], va[23:0]} at level 1 and {desc[31:14], va[17:0]} at level 2.
- R5: A type-0 descriptor ends the walk with fault=1, fault_kind=1 and walk_level set to the faulting level.
- R6: A type-3 descriptor ends the walk with fault=1, fault_kind=2 and walk_level set to the faulting level.
- R7: A type-1 descriptor at level 3 ends the walk with fault=1, fault_kind=3 and walk_level=3.
- R8: The walk performs exactly one read per level visited. `mem_req` is a one-cycle pulse, and no new read is issued before `mem_rvalid` has answered the previous one.
- R9: `done` is high for exactly one cycle per walk. `busy` is high from the cycle after a request is accepted until `done`.
- R10: A `req` raised while `busy` is high is ignored: it changes neither the walk in progress nor its result, and it starts no further reads.
- R11: While reset is held, `busy`, `done` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Start a walk (taken only when idle) |
| va | input | 32 | Virtual address to translate |
| ctx_id | input | 8 | Context (process) number |
| ctx_base | input | 36 | Byte address of the context table |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Descriptor read request, one-cycle pulse |
| mem_addr | output | 36 | Byte address of the descriptor read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Descriptor returned by memory |
| done | output | 1 | Walk finished, one cycle |
| fault | output | 1 | Walk ended without a translation |
| fault_kind | output | 2 | 0 none, 1 absent, 2 reserved type, 3 pointer past last level |
| walk_level | output | 2 | Level of the last descriptor read |
| pa | output | 36 | Physical address |
| attr_acc | output | 3 | Access-protection code |
| attr_c | output | 1 | Cacheable |
| attr_m | output | 1 | Modified |
| attr_r | output | 1 | Referenced |

## Verification
Two endings are hard to reach from the ports. One is a pointer found at the deepest level. The other is an early stop at the context level, where the whole virtual address is carried through. Both need a specific chain of descriptors laid out in memory. The bench rebuilds a small memory image before every walk. It chains pointers down to a chosen level and places the descriptor type under test there. It sweeps every level against every type, across several contexts, table bases, address patterns and read latencies. A stray `req` is injected in the middle of some walks while the walker is busy.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } walk_state_e;

  // descriptor entry type, low two bits of every descriptor
  localparam logic [1:0] ET_ABSENT = 2'd0;
  localparam logic [1:0] ET_TABLE  = 2'd1;
  localparam logic [1:0] ET_LEAF   = 2'd2;
  localparam logic [1:0] ET_RSVD   = 2'd3;

  // fault kinds reported on completion
  localparam logic [1:0] FK_NONE   = 2'd0;
  localparam logic [1:0] FK_ABSENT = 2'd1;
  localparam logic [1:0] FK_RSVD   = 2'd2;
  localparam logic [1:0] FK_DEPTH  = 2'd3;

  localparam logic [1:0] LVL_CTX  = 2'd0;
  localparam logic [1:0] LVL_LAST = 2'd3;

  // final-entry attributes, descriptor bits [7:2]
  typedef struct packed {
    logic [2:0] acc;
    logic       c;
    logic       m;
    logic       r;
  } leaf_attr_t;

  localparam int ATTR_W = 6;

endpackage

// File: rtl/ptw_rst_sync.sv
module ptw_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/ptw_desc_dec.sv
module ptw_desc_dec
  import ptw_pkg::*;
#(
  parameter int DSC_W = 32,
  parameter int PA_W  = 36,
  parameter int PPN_W = 24
) (
  input  logic [DSC_W-1:0] desc,
  output logic [1:0]       etype,
  output logic [PA_W-1:0]  tbl_base,
  output logic [PPN_W-1:0] ppn,
  output leaf_attr_t       attr
);

  localparam int PTR_W     = DSC_W - 2;
  localparam int PTR_SHIFT = PA_W - PTR_W;

  assign etype    = desc[1:0];
  assign tbl_base = {desc[DSC_W-1:2], {PTR_SHIFT{1'b0}}};
  assign ppn      = desc[DSC_W-1 -: PPN_W];
  assign attr     = leaf_attr_t'(desc[2 +: ATTR_W]);

endmodule

// File: rtl/ptw_idx_sel.sv
module ptw_idx_sel #(
  parameter int VPN_W = 20,
  parameter int PA_W  = 36,
  parameter int L1_W  = 8,
  parameter int L2_W  = 6,
  parameter int L3_W  = 6
) (
  input  logic [1:0]       tgt_lvl,
  input  logic [VPN_W-1:0] vpn,
  output logic [PA_W-1:0]  idx_off
);

  localparam int L3_LSB = 0;
  localparam int L2_LSB = L3_W;
  localparam int L1_LSB = L3_W + L2_W;

  logic [L1_W-1:0] idx;

  always_comb begin
    case (tgt_lvl)
      2'd1:    idx = vpn[L1_LSB +: L1_W];
      2'd2:    idx = {{(L1_W-L2_W){1'b0}}, vpn[L2_LSB +: L2_W]};
      2'd3:    idx = {{(L1_W-L3_W){1'b0}}, vpn[L3_LSB +: L3_W]};
      default: idx = '0;
    endcase
  end

  // four bytes per descriptor
  assign idx_off = {{(PA_W-L1_W-2){1'b0}}, idx, 2'b00};

endmodule

// File: rtl/ptw_pa_merge.sv
module ptw_pa_merge #(
  parameter int VPN_W = 20,
  parameter int OFF_W = 12,
  parameter int PPN_W = 24,
  parameter int L2_W  = 6,
  parameter int L3_W  = 6
) (
  input  logic [1:0]             lvl,
  input  logic [PPN_W-1:0]       ppn,
  input  logic [VPN_W-1:0]       vpn,
  input  logic [OFF_W-1:0]       off,
  output logic [PPN_W+OFF_W-1:0] pa
);

  localparam int SPW = $clog2(VPN_W + 1);

  // number of low page-number bits passed through from the virtual address
  logic [SPW-1:0] span;
  logic [PPN_W-1:0] frame;

  always_comb begin
    case (lvl)
      2'd0:    span = SPW'(VPN_W);
      2'd1:    span = SPW'(L2_W + L3_W);
      2'd2:    span = SPW'(L3_W);
      default: span = '0;
    endcase
  end

  for (genvar i = 0; i < PPN_W; i++) begin : g_bit
    if (i < VPN_W) begin : g_mux
      assign frame[i] = (span > SPW'(i)) ? vpn[i] : ppn[i];
    end else begin : g_pass
      assign frame[i] = ppn[i];
    end
  end

  assign pa = {frame, off};

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int PA_W  = 36,
  parameter int CTX_W = 8,
  parameter int DSC_W = 32,
  parameter int OFF_W = 12,
  parameter int L1_W  = 8,
  parameter int L2_W  = 6,
  parameter int L3_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [VA_W-1:0]  va,
  input  logic [CTX_W-1:0] ctx_id,
  input  logic [PA_W-1:0]  ctx_base,
  output logic             busy,
  output logic             mem_req,
  output logic [PA_W-1:0]  mem_addr,
  input  logic             mem_rvalid,
  input  logic [DSC_W-1:0] mem_rdata,
  output logic             done,
  output logic             fault,
  output logic [1:0]       fault_kind,
  output logic [1:0]       walk_level,
  output logic [PA_W-1:0]  pa,
  output logic [2:0]       attr_acc,
  output logic             attr_c,
  output logic             attr_m,
  output logic             attr_r
);

  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;

  logic srst_n;

  walk_state_e     st_q, st_d;
  logic [1:0]      lvl_q, lvl_d;
  logic [VA_W-1:0] va_q, va_d;
  logic [PA_W-1:0] addr_q, addr_d;
  logic            walk_en;

  logic            res_en;
  logic            done_q, done_d;
  logic            fault_q, fault_d;
  logic [1:0]      kind_q, kind_d;
  logic [1:0]      wlvl_q, wlvl_d;
  logic [PA_W-1:0] pa_q, pa_d;
  leaf_attr_t      attr_q, attr_d;

  logic [1:0]       etype;
  logic [PA_W-1:0]  tbl_base;
  logic [PPN_W-1:0] leaf_ppn;
  leaf_attr_t       leaf_attr;
  logic [PA_W-1:0]  idx_off;
  logic [PA_W-1:0]  merged_pa;
  logic [PA_W-1:0]  ctx_off;

  ptw_rst_sync u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  ptw_desc_dec #(
    .DSC_W (DSC_W),
    .PA_W  (PA_W),
    .PPN_W (PPN_W)
  ) u_desc_dec (
    .desc     (mem_rdata),
    .etype    (etype),
    .tbl_base (tbl_base),
    .ppn      (leaf_ppn),
    .attr     (leaf_attr)
  );

  ptw_idx_sel #(
    .VPN_W (VPN_W),
    .PA_W  (PA_W),
    .L1_W  (L1_W),
    .L2_W  (L2_W),
    .L3_W  (L3_W)
  ) u_idx_sel (
    .tgt_lvl (lvl_q + 2'd1),
    .vpn     (va_q[VA_W-1:OFF_W]),
    .idx_off (idx_off)
  );

  ptw_pa_merge #(
    .VPN_W (VPN_W),
    .OFF_W (OFF_W),
    .PPN_W (PPN_W),
    .L2_W  (L2_W),
    .L3_W  (L3_W)
  ) u_pa_merge (
    .lvl (lvl_q),
    .ppn (leaf_ppn),
    .vpn (va_q[VA_W-1:OFF_W]),
    .off (va_q[OFF_W-1:0]),
    .pa  (merged_pa)
  );

  assign ctx_off = {{(PA_W-CTX_W-2){1'b0}}, ctx_id, 2'b00};

  // next-state process
  always_comb begin
    st_d    = st_q;
    lvl_d   = lvl_q;
    va_d    = va_q;
    addr_d  = addr_q;
    walk_en = 1'b0;
    res_en  = 1'b0;
    done_d  = 1'b0;
    fault_d = fault_q;
    kind_d  = kind_q;
    wlvl_d  = wlvl_q;
    pa_d    = pa_q;
    attr_d  = attr_q;

    case (st_q)
      ST_IDLE: begin
        if (req) begin
          walk_en = 1'b1;
          va_d    = va;
          lvl_d   = LVL_CTX;
          addr_d  = ctx_base + ctx_off;
          st_d    = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        st_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (mem_rvalid) begin
          if (etype == ET_TABLE && lvl_q != LVL_LAST) begin
            walk_en = 1'b1;
            lvl_d   = lvl_q + 2'd1;
            addr_d  = tbl_base + idx_off;
            st_d    = ST_ISSUE;
          end else begin
            res_en = 1'b1;
            done_d = 1'b1;
            wlvl_d = lvl_q;
            st_d   = ST_IDLE;
            case (etype)
              ET_LEAF:   kind_d = FK_NONE;
              ET_ABSENT: kind_d = FK_ABSENT;
              ET_RSVD:   kind_d = FK_RSVD;
              default:   kind_d = FK_DEPTH;
            endcase
            fault_d = (etype != ET_LEAF);
            pa_d    = (etype == ET_LEAF) ? merged_pa : '0;
            attr_d  = (etype == ET_LEAF) ? leaf_attr : '0;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q    <= ST_IDLE;
      lvl_q   <= LVL_CTX;
      va_q    <= '0;
      addr_q  <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      kind_q  <= FK_NONE;
      wlvl_q  <= LVL_CTX;
      pa_q    <= '0;
      attr_q  <= '0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      if (walk_en) begin
        lvl_q  <= lvl_d;
        va_q   <= va_d;
        addr_q <= addr_d;
      end
      if (res_en) begin
        fault_q <= fault_d;
        kind_q  <= kind_d;
        wlvl_q  <= wlvl_d;
        pa_q    <= pa_d;
        attr_q  <= attr_d;
      end
    end
  end

  assign busy       = (st_q != ST_IDLE);
  assign mem_req    = (st_q == ST_ISSUE);
  assign mem_addr   = addr_q;
  assign done       = done_q;
  assign fault      = fault_q;
  assign fault_kind = kind_q;
  assign walk_level = wlvl_q;
  assign pa         = pa_q;
  assign attr_acc   = attr_q.acc;
  assign attr_c     = attr_q.c;
  assign attr_m     = attr_q.m;
  assign attr_r     = attr_q.r;

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req,
  input logic       busy,
  input logic       mem_req,
  input logic       mem_rvalid,
  input logic       done,
  input logic       fault,
  input logic [1:0] fault_kind,
  input logic [1:0] walk_level
);

  // one read in flight: set by a request, cleared by its answer
  logic outst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outst_q <= 1'b0;
    end else if (mem_req) begin
      outst_q <= 1'b1;
    end else if (mem_rvalid) begin
      outst_q <= 1'b0;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R9

  AST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !busy) |=> busy); // R9

  AST_READ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req); // R8

  AST_READ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy); // R8

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !outst_q); // R8

  AST_FAULT_CODED: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |-> (fault_kind != 2'd0)); // R5

  AST_OK_UNCODED: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault) |-> (fault_kind == 2'd0)); // R3

  AST_DEPTH_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault_kind == 2'd3) |-> (walk_level == 2'd3)); // R7

endmodule

bind ptw_walker ptw_walker_chk u_chk (
  .clk        (clk),
  .rst_n      (srst_n),
  .req        (req),
  .busy       (busy),
  .mem_req    (mem_req),
  .mem_rvalid (mem_rvalid),
  .done       (done),
  .fault      (fault),
  .fault_kind (fault_kind),
  .walk_level (walk_level)
);

// File: tb/ptw_walker_tb.sv
`timescale 1ns/1ps
module ptw_walker_tb;

  logic        clk;
  logic        rst_n;
  logic        req;
  logic [31:0] va_in;
  logic [7:0]  ctx_in;
  logic [35:0] base_in;
  logic        busy;
  logic        mem_req;
  logic [35:0] mem_addr;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;
  logic        done;
  logic        fault;
  logic [1:0]  fault_kind;
  logic [1:0]  walk_level;
  logic [35:0] pa;
  logic [2:0]  attr_acc;
  logic        attr_c, attr_m, attr_r;

  int checks = 0;
  int fails  = 0;

  ptw_walker u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .va         (va_in),
    .ctx_id     (ctx_in),
    .ctx_base   (base_in),
    .busy       (busy),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .done       (done),
    .fault      (fault),
    .fault_kind (fault_kind),
    .walk_level (walk_level),
    .pa         (pa),
    .attr_acc   (attr_acc),
    .attr_c     (attr_c),
    .attr_m     (attr_m),
    .attr_r     (attr_r)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // memory model: 16 KB of descriptors, one request at a time
  logic [31:0] mem [4096];
  logic [35:0] rec_addr [8];
  int          total_reads = 0;
  int          mem_lat = 1;
  int          cnt = 0;
  logic        pend = 1'b0;
  logic [35:0] paddr = '0;
  logic        overlap_err = 1'b0;
  logic        range_err = 1'b0;

  initial begin
    mem_rvalid = 1'b0;
    mem_rdata  = '0;
  end

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (mem_req) begin
      if (pend) overlap_err <= 1'b1;
      if (mem_addr[35:14] != '0) range_err <= 1'b1;
      pend        <= 1'b1;
      cnt         <= mem_lat;
      paddr       <= mem_addr;
      rec_addr[total_reads % 8] <= mem_addr;
      total_reads <= total_reads + 1;
    end else if (pend) begin
      if (cnt <= 1) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem[paddr[13:2]];
        pend       <= 1'b0;
      end else begin
        cnt <= cnt - 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ptr_desc(input logic [35:0] b);
    return {b[35:6], 2'b01};
  endfunction

  function automatic logic [35:0] exp_pa(input int lvl, input logic [23:0] p, input logic [31:0] v);
    case (lvl)
      0:       return {p[23:20], v};
      1:       return {p[23:12], v[23:0]};
      2:       return {p[23:6], v[17:0]};
      default: return {p, v[11:0]};
    endcase
  endfunction

  task automatic run_walk(input logic [7:0] ctx, input logic [35:0] cbase, input int lvl,
                          input logic [1:0] ty, input logic [31:0] v, input int lat, input bit poke);
    logic [23:0] ppn;
    logic [2:0]  acc;
    logic [31:0] leaf;
    logic [35:0] exp_a [4];
    logic [1:0]  ek;
    int          start_rd;
    int          after_rd;
    bit          seen;

    for (int w = 0; w < 4096; w++) mem[w] = '0;
    ppn  = 24'hC35A17 ^ {v[7:0], ctx, 8'(lvl * 37)} ^ {22'h0, ty};
    acc  = 3'(ctx + 8'(lvl));
    leaf = {ppn, acc, v[0], v[1], v[2], ty};
    exp_a[0] = cbase + {26'h0, ctx, 2'b00};
    exp_a[1] = 36'h1000 + {26'h0, v[31:24], 2'b00};
    exp_a[2] = 36'h2000 + {28'h0, v[23:18], 2'b00};
    exp_a[3] = 36'h3000 + {28'h0, v[17:12], 2'b00};
    for (int k = 0; k < 4; k++) begin
      if (k < lvl) mem[exp_a[k][13:2]] = ptr_desc(36'(4096 * (k + 1)));
      else if (k == lvl) mem[exp_a[k][13:2]] = leaf;
    end
    mem_lat  = lat;
    start_rd = total_reads;

    @(negedge clk);
    req = 1'b1; va_in = v; ctx_in = ctx; base_in = cbase;
    @(negedge clk);
    req = 1'b0; va_in = ~v; ctx_in = ~ctx; base_in = 36'h0_0000_3FFC;

    seen = 1'b0;
    for (int k = 0; k < 400 && !seen; k++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
      else if (poke && k == 0) req = 1'b1;
      if (k >= 1) req = 1'b0;
    end
    req = 1'b0;
    chk(seen, "R9 done reached", 64'(seen), 64'd1);

    case (ty)
      2'd0:    ek = 2'd1;
      2'd3:    ek = 2'd2;
      2'd1:    ek = 2'd3;
      default: ek = 2'd0;
    endcase
    if (ty == 2'd0) chk(fault && fault_kind == ek, "R5 absent fault", {fault, fault_kind}, {1'b1, ek});
    if (ty == 2'd3) chk(fault && fault_kind == ek, "R6 reserved fault", {fault, fault_kind}, {1'b1, ek});
    if (ty == 2'd1) chk(fault && fault_kind == ek, "R7 depth fault", {fault, fault_kind}, {1'b1, ek});
    chk(walk_level == 2'(lvl), "R4 walk_level", 64'(walk_level), 64'(lvl));
    if (ty == 2'd2) begin
      if (lvl == 3) begin
        chk(!fault && fault_kind == 2'd0, "R3 no fault", {fault, fault_kind}, 64'd0);
        chk(pa == exp_pa(lvl, ppn, v), "R3 pa", 64'(pa), 64'(exp_pa(lvl, ppn, v)));
        chk({attr_acc, attr_c, attr_m, attr_r} == leaf[7:2], "R3 attributes",
            {attr_acc, attr_c, attr_m, attr_r}, 64'(leaf[7:2]));
      end else begin
        chk(!fault && fault_kind == 2'd0, "R4 no fault", {fault, fault_kind}, 64'd0);
        chk(pa == exp_pa(lvl, ppn, v), "R4 pa", 64'(pa), 64'(exp_pa(lvl, ppn, v)));
        chk({attr_acc, attr_c, attr_m, attr_r} == leaf[7:2], "R4 attributes",
            {attr_acc, attr_c, attr_m, attr_r}, 64'(leaf[7:2]));
      end
    end

    chk(total_reads - start_rd == lvl + 1, "R8 read count", 64'(total_reads - start_rd), 64'(lvl + 1));
    chk(rec_addr[start_rd % 8] == exp_a[0], "R1 context read address",
        64'(rec_addr[start_rd % 8]), 64'(exp_a[0]));
    for (int k = 1; k <= lvl; k++) begin
      chk(rec_addr[(start_rd + k) % 8] == exp_a[k], "R2 table read address",
          64'(rec_addr[(start_rd + k) % 8]), 64'(exp_a[k]));
    end

    @(negedge clk);
    chk(!done, "R9 done single cycle", 64'(done), 64'd0);
    after_rd = total_reads;
    repeat (3) @(negedge clk);
    if (poke) begin
      chk(!busy && total_reads == after_rd, "R10 request while busy ignored",
          {busy, 32'(total_reads)}, {1'b0, 32'(after_rd)});
    end else begin
      chk(!busy, "R9 idle after done", 64'(busy), 64'd0);
    end
  endtask

  logic [7:0]  ctxs [4] = '{8'd0, 8'd3, 8'd128, 8'd255};
  logic [31:0] vas  [3] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'hA5C3_96E1};

  initial begin
    rst_n = 1'b0; req = 1'b0; va_in = '0; ctx_in = '0; base_in = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req, "R11 reset state", {busy, done, mem_req}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int ci = 0; ci < 4; ci++) begin
      for (int lv = 0; lv < 4; lv++) begin
        for (int t = 0; t < 4; t++) begin
          if (t == 1 && lv < 3) continue;
          for (int vi = 0; vi < 3; vi++) begin
            run_walk(ctxs[ci], (ci % 2 == 1) ? 36'h1F0 : 36'h0, lv, 2'(t),
                     vas[vi] ^ {ctxs[ci], 8'(lv), 16'(t * 4099)}, 1 + vi, vi == 2);
          end
        end
      end
    end

    chk(!overlap_err, "R8 single outstanding read", 64'(overlap_err), 64'd0);
    chk(!range_err, "R2 reads inside table area", 64'(range_err), 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R9 watchdog expired actual=%0h expected=%0h", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule